// File: doc/BRIEF.md
# Parallel MSB-First Frame Check Sequence Generator

This block computes a 32-bit frame check sequence for a byte-oriented HDLC-style link. It takes several bytes per clock and does the work that a one-bit-per-clock shift register would do. The generator polynomial is 0x04C11DB7. Each byte enters the calculation in line order, most significant bit first, and the lowest-numbered lane is the first byte on the line. The result is the ones' complement of the final register value, so it is ready to append to the frame.

A frame is a run of accepted beats. The first beat carries a start marker and the last carries an end marker. On the end beat a lane count gives the number of leading lanes that hold frame bytes, so frame lengths need not be a multiple of the bus width. One clock after the end beat, the complemented result appears together with a one-cycle valid pulse. The result then holds until the next end beat.

Top module: `fcs_par_gen`

## Requirements
- R1: Each accepted byte updates the register once per bit, bit 7 first: feedback = c[31] XOR bit, then c = (c << 1) XOR (feedback ? 0x04C11DB7 : 0). Lane 0 occupies `beat_data[31:24]` and is processed first, lane 3 is `beat_data[7:0]` and is processed last. For the nine ASCII bytes "123456789", `fcs` equals 0xFC891918.
- R2: On an accepted beat with `frm_start` high, the update starts from 0xFFFFFFFF regardless of the earlier register content, so identical frames give identical results.
- R3: One cycle after an accepted beat with `frm_end` high, `fcs` equals the bitwise complement of the register after that beat and `fcs_vld` is high for exactly that one cycle. In every other cycle `fcs_vld` is low.
- R4: On an end beat only the first `lane_cnt` lanes update the register. The bytes in the remaining lanes have no effect. A count above 4 is treated as 4, and a count of 0 leaves the register unchanged.
- R5: On accepted beats without `frm_end`, `lane_cnt` is ignored and all 4 lanes are processed.
- R6: While `beat_vld` is low, the data, start, end and count inputs are ignored: the register, `fcs` and `fcs_vld` (low) are unaffected.
- R7: While `rst_n` is low, `fcs` is 0 and `fcs_vld` is 0.
- R8: A beat with both `frm_start` and `frm_end` high forms a complete frame of 1 to 4 bytes.
- R9: A start beat in the middle of a frame abandons the partial frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_vld | input | 1 | Beat accepted this cycle |
| frm_start | input | 1 | First beat of a frame |
| frm_end | input | 1 | Last beat of a frame |
| lane_cnt | input | 3 | Number of leading valid lanes on the end beat |
| beat_data | input | 32 | Four bytes; lane 0 is bits 31:24 and is first on the line |
| fcs | output | 32 | Complemented check value of the last completed frame |
| fcs_vld | output | 1 | One-cycle pulse when `fcs` is updated |

## Verification
The bench runs frames of 1 to 64 bytes through the generator and compares each result with a bit-serial model, so every residue of the length modulo 4 is covered. Frames that fit in a single beat show whether the preset and the end handling work on the same beat. Some frames carry junk lane counts on their middle beats, junk in their unused lanes, or idle gaps that hold junk markers. These frames show that the count is ignored mid-frame, that the unused lanes are masked, and that the register holds while the bus is idle. Directed cases give a known check string against a fixed constant, an end beat with a count of 0, a count above the bus width, a restart in mid-frame and a reset between frames. The fixed constant separates a wrong bit order or polynomial from a model that shares the same error.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // One byte through the serial shift, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_byte_msb(
    input logic [CRC_W-1:0]  c_in,
    input logic [BYTE_W-1:0] b_in,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ b_in[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/fcs_lane_chain.sv
module fcs_lane_chain
  import fcs_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  localparam int unsigned DATA_W = LANES * BYTE_W,
  localparam int unsigned TAP_W  = CRC_W * (LANES + 1)
) (
  input  logic [CRC_W-1:0]  base,
  input  logic [DATA_W-1:0] data,
  output logic [TAP_W-1:0]  taps
);
  // taps slice k holds the register after the first k lanes.
  assign taps[CRC_W-1:0] = base;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] lane_byte;
    assign lane_byte = data[DATA_W-1-k*BYTE_W -: BYTE_W];
    assign taps[(k+1)*CRC_W +: CRC_W] =
      crc_byte_msb(taps[k*CRC_W +: CRC_W], lane_byte, POLY);
  end
endmodule

// File: rtl/fcs_tap_mux.sv
module fcs_tap_mux
  import fcs_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned TAP_W = CRC_W * (LANES + 1)
) (
  input  logic [TAP_W-1:0] taps,
  input  logic             is_end,
  input  logic [CNT_W-1:0] lane_cnt,
  output logic [CRC_W-1:0] crc_sel
);
  logic [CNT_W-1:0] eff_cnt;

  always_comb begin
    if (!is_end || (lane_cnt > CNT_W'(LANES))) begin
      eff_cnt = CNT_W'(LANES);
    end else begin
      eff_cnt = lane_cnt;
    end
  end

  always_comb begin
    crc_sel = taps[CRC_W-1:0];
    for (int k = 1; k <= LANES; k++) begin
      if (eff_cnt == CNT_W'(k)) begin
        crc_sel = taps[k*CRC_W +: CRC_W];
      end
    end
  end
endmodule

// File: rtl/fcs_state_reg.sv
module fcs_state_reg
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             end_en,
  input  logic [CRC_W-1:0] crc_d,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] fcs_q,
  output logic             vld_q
);
  logic [CRC_W-1:0] crc_nxt;
  logic [CRC_W-1:0] fcs_nxt;
  logic             vld_nxt;

  always_comb begin
    crc_nxt = crc_q;
    fcs_nxt = fcs_q;
    vld_nxt = 1'b0;
    if (upd_en) begin
      crc_nxt = crc_d;
    end
    if (upd_en && end_en) begin
      fcs_nxt = ~crc_d;
      vld_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
      fcs_q <= '0;
      vld_q <= 1'b0;
    end else begin
      crc_q <= crc_nxt;
      fcs_q <= fcs_nxt;
      vld_q <= vld_nxt;
    end
  end
endmodule

// File: rtl/fcs_par_gen.sv
module fcs_par_gen
  import fcs_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  localparam int unsigned DATA_W = LANES * BYTE_W,
  localparam int unsigned CNT_W  = $clog2(LANES + 1),
  localparam int unsigned TAP_W  = CRC_W * (LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic [CNT_W-1:0]  lane_cnt,
  input  logic [DATA_W-1:0] beat_data,
  output logic [CRC_W-1:0]  fcs,
  output logic              fcs_vld
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_d;
  logic [TAP_W-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign crc_base = frm_start ? '1 : crc_q;

  fcs_lane_chain #(.LANES(LANES), .POLY(POLY)) u_chain (
    .base (crc_base),
    .data (beat_data),
    .taps (taps)
  );

  fcs_tap_mux #(.LANES(LANES)) u_mux (
    .taps     (taps),
    .is_end   (frm_end),
    .lane_cnt (lane_cnt),
    .crc_sel  (crc_d)
  );

  fcs_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (beat_vld),
    .end_en (frm_end),
    .crc_d  (crc_d),
    .crc_q  (crc_q),
    .fcs_q  (fcs),
    .vld_q  (fcs_vld)
  );
endmodule

// File: rtl/fcs_par_gen_chk.sv
module fcs_par_gen_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             beat_vld,
  input logic             frm_start,
  input logic             frm_end,
  input logic [CNT_W-1:0] lane_cnt,
  input logic [31:0]      crc_q,
  input logic [31:0]      fcs,
  input logic             fcs_vld
);
  p_vld_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (beat_vld && frm_end) |=> fcs_vld);

  p_vld_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !(beat_vld && frm_end) |=> !fcs_vld);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !beat_vld |=> ($stable(fcs) && $stable(crc_q)));

  p_empty_end_r4: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (beat_vld && frm_end && !frm_start && (lane_cnt == '0)) |=> (fcs == ~$past(crc_q)));

  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (beat_vld && frm_start && frm_end && (lane_cnt == '0)) |=> (fcs == 32'h0));

  always_comb begin
    if (!rst_n) begin
      a_reset_out_r7: assert (fcs_vld == 1'b0);
    end
  end
endmodule

bind fcs_par_gen fcs_par_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .beat_vld   (beat_vld),
  .frm_start  (frm_start),
  .frm_end    (frm_end),
  .lane_cnt   (lane_cnt),
  .crc_q      (crc_q),
  .fcs        (fcs),
  .fcs_vld    (fcs_vld)
);

// File: tb/fcs_par_gen_tb_top.sv
module fcs_par_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        beat_vld;
  logic        frm_start;
  logic        frm_end;
  logic [2:0]  lane_cnt;
  logic [31:0] beat_data;
  logic [31:0] fcs;
  logic        fcs_vld;

  int n_chk;
  int n_bad;
  bit done;

  logic [7:0] fbuf [0:255];

  localparam int NV = 14;
  localparam int LEN_TBL  [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 13, 16, 31, 33, 64};
  localparam int SEED_TBL [NV] = '{3, 9, 17, 22, 40, 51, 66, 70, 81, 99, 120, 133, 150, 201};

  fcs_par_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (beat_vld),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .lane_cnt  (lane_cnt),
    .beat_data (beat_data),
    .fcs       (fcs),
    .fcs_vld   (fcs_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_fcs(input int len);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[31] ^ fbuf[i][b];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return ~c;
  endfunction

  task automatic fill(input int seed, input int len);
    for (int i = 0; i < len; i++) begin
      fbuf[i] = 8'(((i * 37) + (seed * 11) + (i >> 3)) ^ seed);
    end
  endtask

  task automatic idle();
    beat_vld  = 1'b0;
    frm_start = 1'b0;
    frm_end   = 1'b0;
    lane_cnt  = 3'd0;
    beat_data = 32'h0;
  endtask

  // Called at a falling edge; returns at a falling edge after checks.
  task automatic send_frame(input int len, input bit junk, input int gap,
                            input bit clamp, input string req);
    int nb;
    int rem;
    logic [31:0] exp;
    nb  = (len + 3) / 4;
    rem = len % 4;
    exp = model_fcs(len);
    for (int b = 0; b < nb; b++) begin
      beat_vld  = 1'b1;
      frm_start = (b == 0);
      frm_end   = (b == nb - 1);
      for (int k = 0; k < 4; k++) begin
        if (b * 4 + k < len) beat_data[31-8*k -: 8] = fbuf[b*4+k];
        else                 beat_data[31-8*k -: 8] = 8'hA5 ^ 8'(k * 29);
      end
      if (b == nb - 1) lane_cnt = (rem == 0) ? (clamp ? 3'd7 : 3'd4) : 3'(rem);
      else             lane_cnt = junk ? 3'(b % 4) : 3'd4;
      @(negedge clk);
      if (gap > 0 && b != nb - 1) begin
        beat_vld  = 1'b0;
        frm_start = 1'b1;
        frm_end   = 1'b1;
        lane_cnt  = 3'd1;
        beat_data = 32'hDEADBEEF;
        repeat (gap) @(negedge clk);
        chk(fcs_vld == 1'b0, "R6 no pulse while idle", 32'(fcs_vld), 32'h0);
      end
    end
    idle();
    chk(fcs_vld == 1'b1, {req, " fcs_vld pulse"}, 32'(fcs_vld), 32'h1);
    chk(fcs == exp, req, fcs, exp);
    @(negedge clk);
    chk(fcs_vld == 1'b0, "R3 pulse one cycle", 32'(fcs_vld), 32'h0);
    chk(fcs == exp, "R3 fcs holds", fcs, exp);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    idle();
    repeat (4) @(negedge clk);
    chk(fcs == 32'h0, "R7 reset fcs", fcs, 32'h0);
    chk(fcs_vld == 1'b0, "R7 reset fcs_vld", 32'(fcs_vld), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: lengths of every residue; R1, R4 masking, R5, R6, R8.
    for (int v = 0; v < NV; v++) begin
      fill(SEED_TBL[v], LEN_TBL[v]);
      send_frame(LEN_TBL[v], v[0], (v % 3 == 2) ? 2 : 0, 1'b0,
                 (LEN_TBL[v] <= 4) ? "R8 single beat" : "R1 serial match");
    end

    // R1 fixed check string.
    for (int i = 0; i < 9; i++) fbuf[i] = 8'h31 + 8'(i);
    send_frame(9, 1'b0, 0, 1'b0, "R1 check string");
    chk(fcs == 32'hFC891918, "R1 check constant", fcs, 32'hFC891918);

    // R2 same frame again yields same result.
    send_frame(9, 1'b1, 1, 1'b0, "R2 preset repeat");

    // R4 count above width clamps.
    fill(7, 12);
    send_frame(12, 1'b0, 0, 1'b1, "R4 count clamp");

    // R4 end beat with count 0.
    fill(12, 8);
    for (int b = 0; b < 2; b++) begin
      beat_vld = 1'b1; frm_start = (b == 0); frm_end = 1'b0; lane_cnt = 3'd4;
      beat_data = {fbuf[b*4], fbuf[b*4+1], fbuf[b*4+2], fbuf[b*4+3]};
      @(negedge clk);
    end
    beat_vld = 1'b1; frm_start = 1'b0; frm_end = 1'b1; lane_cnt = 3'd0;
    beat_data = 32'h12345678;
    @(negedge clk);
    idle();
    chk(fcs_vld == 1'b1, "R4 empty end pulse", 32'(fcs_vld), 32'h1);
    chk(fcs == model_fcs(8), "R4 empty end", fcs, model_fcs(8));
    @(negedge clk);

    // R2 start+end with count 0 gives complement of preset.
    beat_vld = 1'b1; frm_start = 1'b1; frm_end = 1'b1; lane_cnt = 3'd0;
    beat_data = 32'hCAFEF00D;
    @(negedge clk);
    idle();
    chk(fcs == 32'h0, "R2 empty frame", fcs, 32'h0);
    @(negedge clk);

    // R9 restart mid-frame.
    for (int b = 0; b < 2; b++) begin
      beat_vld = 1'b1; frm_start = (b == 0); frm_end = 1'b0; lane_cnt = 3'd4;
      beat_data = 32'h55AA0000 + 32'(b);
      @(negedge clk);
    end
    fill(77, 10);
    send_frame(10, 1'b0, 0, 1'b0, "R9 restart");

    // R7 reset after a frame.
    rst_n = 1'b0;
    #1;
    chk(fcs == 32'h0, "R7 reset mid-run fcs", fcs, 32'h0);
    chk(fcs_vld == 1'b0, "R7 reset mid-run vld", 32'(fcs_vld), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fill(5, 6);
    send_frame(6, 1'b0, 0, 1'b0, "R1 after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule